// File: doc/BRIEF.md
# Transmit-Only Serial Display Link

This block carries command and data bytes from a ready/valid source to a small TFT display controller over a four-wire serial link that only transmits. Each input byte carries a type flag that marks it as a command or as data. The block drives the serial clock, the serial data line, an active-low chip select and a command/data select line. There is no receive line.

After system reset the block first runs a power-up sequence on the controller's active-low reset pin. It holds the pin low for a set number of cycles, releases it, and waits a further set number of cycles before it accepts any byte. After that, each byte is shifted out most-significant bit first in clock mode 0: the clock idles low and the receiver samples on the rising edge.

Bytes of the same type that arrive back to back share one chip-select window. The window closes when the type changes or when no byte is waiting at a byte boundary. The serial clock period is twice a parameterized number of system clock cycles.

Top module: `lcd_spi_link`

## Requirements
- R1: `lcd_rst_n` is low from system reset until exactly RST_LOW_CYC clock edges after `rst_n` is released. It is high from then on.
- R2: `in_ready` stays low until RST_LOW_CYC + RST_WAIT_CYC clock edges after reset release, and is never high while `lcd_rst_n` is low.
- R3: `lcd_sck` is low whenever `lcd_cs_n` is high. Within one byte, consecutive rising edges of `lcd_sck` are exactly 2×CLK_DIV_N system cycles apart.
- R4: Each byte goes out as exactly eight rising edges of `lcd_sck`, most-significant bit first, with the bit value on `lcd_mosi` at each rising edge. `lcd_mosi` does not change while `lcd_sck` is high.
- R5: `lcd_dc` is 0 for a command byte (`in_is_data`=0) and 1 for a data byte (`in_is_data`=1). It does not change while `lcd_cs_n` is low.
- R6: `lcd_dc` has held its value for at least CLK_DIV_N cycles when `lcd_cs_n` falls.
- R7: A byte offered in the cycle after the previous byte was accepted, with the same type, goes out in the same chip-select window. A byte of the other type goes out in a new window.
- R8: When no byte is offered at a byte boundary, `lcd_cs_n` returns high and `lcd_sck` stays low until the next byte.
- R9: A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. Every accepted byte is sent exactly once, in order.
- R10: While `rst_n` is low: `lcd_cs_n`=1, `lcd_sck`=0, `lcd_rst_n`=0 and `in_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| in_byte | input | 8 | Byte to transmit |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| lcd_sck | output | 1 | Serial clock, idles low |
| lcd_mosi | output | 1 | Serial data, MSB first |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_dc | output | 1 | Command (0) / data (1) select |
| lcd_rst_n | output | 1 | Active-low controller reset |

## Verification
The assertions assume that the source holds `in_byte` and `in_is_data` steady while `in_valid` waits for `in_ready`. They also assume that both reset counts and the divider value are at least 1. The stimulus changes inputs only on falling clock edges, and only right after an acceptance or after an idle gap. The gaps come in two kinds: none at all, or longer than a whole byte. This means every byte has a single expected chip-select outcome. The random byte values and type changes cover both the chained and the reopened windows.

// File: rtl/spi_lcd_pkg.sv
package spi_lcd_pkg;

    typedef enum logic [2:0] {
        SER_IDLE  = 3'd0,
        SER_SETUP = 3'd1,
        SER_LO    = 3'd2,
        SER_HI    = 3'd3,
        SER_END   = 3'd4
    } ser_state_e;

    typedef enum logic [1:0] {
        PWR_HOLD = 2'd0,
        PWR_WAIT = 2'd1,
        PWR_DONE = 2'd2
    } pwr_state_e;

    typedef struct packed {
        ser_state_e st;
        logic [7:0] sh;
        logic [2:0] bits;
        logic       sck;
        logic       cs_n;
        logic       dc;
    } ser_regs_t;

endpackage

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import spi_lcd_pkg::*;
#(
    parameter int HOLD_CYC = 200,
    parameter int WAIT_CYC = 1200
) (
    input  logic clk,
    input  logic rst_n,
    output logic ctl_rst_n,
    output logic init_done
);
    localparam int MAXC = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [CW-1:0] cnt;
        logic          out;
        logic          done;
    } pwr_regs_t;

    pwr_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            PWR_HOLD: begin
                if (s_q.cnt == CW'(HOLD_CYC - 1)) begin
                    s_d.st  = PWR_WAIT;
                    s_d.cnt = '0;
                    s_d.out = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PWR_WAIT: begin
                if (s_q.cnt == CW'(WAIT_CYC - 1)) begin
                    s_d.st   = PWR_DONE;
                    s_d.cnt  = '0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: PWR_HOLD, cnt: '0, out: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_rst_n = s_q.out;
    assign init_done = s_q.done;

    AST_RST_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_q.out) |-> s_q.out); // R1

endmodule

// File: rtl/lcd_sck_div.sv
module lcd_sck_div #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [DW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == DW'(HALF_CYC - 1));

    always_comb begin
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lcd_byte_ser.sv
module lcd_byte_ser
    import spi_lcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tick,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_data,
    output logic       run,
    output logic       sck,
    output logic       mosi,
    output logic       cs_n,
    output logic       dc
);
    ser_regs_t s_d, s_q;
    logic      take;

    assign in_ready = enable && ((s_q.st == SER_IDLE) || ((s_q.st == SER_END) && tick));
    assign take     = in_ready && in_valid;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SER_IDLE: begin
                if (take) begin
                    s_d.st   = SER_SETUP;
                    s_d.sh   = in_byte;
                    s_d.bits = '0;
                    s_d.dc   = in_is_data;
                end
            end
            SER_SETUP: begin
                if (tick) begin
                    s_d.st = SER_LO;
                end
            end
            SER_LO: begin
                if (tick) begin
                    s_d.st = SER_HI;
                end
            end
            SER_HI: begin
                if (tick) begin
                    if (s_q.bits == 3'd7) begin
                        s_d.st = SER_END;
                    end else begin
                        s_d.st   = SER_LO;
                        s_d.sh   = {s_q.sh[6:0], 1'b0};
                        s_d.bits = s_q.bits + 1'b1;
                    end
                end
            end
            SER_END: begin
                if (tick) begin
                    if (take) begin
                        s_d.sh   = in_byte;
                        s_d.bits = '0;
                        if (in_is_data == s_q.dc) begin
                            s_d.st = SER_LO;
                        end else begin
                            s_d.st = SER_SETUP;
                            s_d.dc = in_is_data;
                        end
                    end else begin
                        s_d.st = SER_IDLE;
                    end
                end
            end
            default: s_d.st = SER_IDLE;
        endcase
        s_d.sck  = (s_d.st == SER_HI);
        s_d.cs_n = !(s_d.st inside {SER_LO, SER_HI, SER_END});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SER_IDLE, sh: '0, bits: '0, sck: 1'b0, cs_n: 1'b1, dc: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign run  = (s_q.st != SER_IDLE);
    assign sck  = s_q.sck;
    assign mosi = s_q.sh[7];
    assign cs_n = s_q.cs_n;
    assign dc   = s_q.dc;

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cs_n |-> !s_q.sck); // R3

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sck |-> $stable(s_q.sh[7])); // R4

    AST_DC_HELD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cs_n |-> $stable(s_q.dc)); // R5

endmodule

// File: rtl/lcd_spi_link.sv
module lcd_spi_link #(
    parameter int CLK_DIV_N    = 2,
    parameter int RST_LOW_CYC  = 200,
    parameter int RST_WAIT_CYC = 1200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_data,
    output logic       lcd_sck,
    output logic       lcd_mosi,
    output logic       lcd_cs_n,
    output logic       lcd_dc,
    output logic       lcd_rst_n
);
    logic init_done;
    logic ser_run;
    logic half_tick;

    lcd_pwr_seq #(
        .HOLD_CYC (RST_LOW_CYC),
        .WAIT_CYC (RST_WAIT_CYC)
    ) pwr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_rst_n (lcd_rst_n),
        .init_done (init_done)
    );

    lcd_sck_div #(
        .HALF_CYC (CLK_DIV_N)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ser_run),
        .tick  (half_tick)
    );

    lcd_byte_ser ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (init_done),
        .tick       (half_tick),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_byte    (in_byte),
        .in_is_data (in_is_data),
        .run        (ser_run),
        .sck        (lcd_sck),
        .mosi       (lcd_mosi),
        .cs_n       (lcd_cs_n),
        .dc         (lcd_dc)
    );

    AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> !in_ready); // R2

    AST_CS_IDLE_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> lcd_cs_n); // R2

endmodule

// File: tb/lcd_spi_link_tb_top.sv
module lcd_spi_link_tb_top;

    localparam int DIV   = 3;
    localparam int RLOW  = 12;
    localparam int RWAIT = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       in_is_data = 1'b0;
    logic       lcd_sck, lcd_mosi, lcd_cs_n, lcd_dc, lcd_rst_n;

    always #5 clk = ~clk;

    lcd_spi_link #(
        .CLK_DIV_N    (DIV),
        .RST_LOW_CYC  (RLOW),
        .RST_WAIT_CYC (RWAIT)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_byte    (in_byte),
        .in_is_data (in_is_data),
        .lcd_sck    (lcd_sck),
        .lcd_mosi   (lcd_mosi),
        .lcd_cs_n   (lcd_cs_n),
        .lcd_dc     (lcd_dc),
        .lcd_rst_n  (lcd_rst_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit want_new_frame(bit first, bit gap, bit isd, bit prev_isd);
        return first || gap || (isd != prev_isd);
    endfunction

    function automatic int idle_gap(int r);
        return 20 * DIV + 5 + (r % 8);
    endfunction

    // expected stream: {new_frame, is_data, byte}
    logic [9:0] exp_q[$];
    int sent = 0;
    int got  = 0;

    // monitor state
    bit   mon_en = 0;
    int   cyc = 0;
    logic p_sck = 0, p_cs_n = 1, p_dc = 0;
    logic rise_mosi = 0;
    logic dc_at_fall = 0;
    int   dc_chg_cyc = 0;
    int   last_rise = 0;
    int   bitcnt = 0;
    logic [7:0] rx = 0;
    bit   frame_new = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (lcd_dc != p_dc) dc_chg_cyc = cyc;
            if (lcd_cs_n && lcd_sck)
                check(0, "R3 sck high with cs released", 1, 0);
            if (p_cs_n && !lcd_cs_n) begin
                check(cyc - dc_chg_cyc >= DIV, "R6 dc setup cycles", cyc - dc_chg_cyc, DIV);
                check(bitcnt == 0, "R4 window opened mid-byte", bitcnt, 0);
                dc_at_fall = lcd_dc;
                frame_new  = 1;
            end
            if (!p_cs_n && lcd_cs_n && bitcnt != 0)
                check(0, "R4 window closed mid-byte", bitcnt, 0);
            if (p_sck && lcd_sck && lcd_mosi != rise_mosi)
                check(0, "R4 mosi moved while sck high", lcd_mosi, rise_mosi);
            if (!p_sck && lcd_sck) begin
                if (lcd_dc != dc_at_fall)
                    check(0, "R5 dc changed inside window", lcd_dc, dc_at_fall);
                if (bitcnt != 0)
                    check(cyc - last_rise == 2 * DIV, "R3 sck period", cyc - last_rise, 2 * DIV);
                last_rise = cyc;
                rise_mosi = lcd_mosi;
                rx = {rx[6:0], lcd_mosi};
                bitcnt++;
                if (bitcnt == 8) begin
                    bitcnt = 0;
                    got++;
                    if (exp_q.size() == 0) begin
                        check(0, "R9 unexpected byte", rx, 0);
                    end else begin
                        logic [9:0] e;
                        e = exp_q.pop_front();
                        check(rx == e[7:0], "R4 byte value", rx, e[7:0]);
                        check(lcd_dc == e[8], "R5 dc level", lcd_dc, e[8]);
                        check(frame_new == e[9], "R7 R8 new window", frame_new, e[9]);
                    end
                    frame_new = 0;
                end
            end
        end
        p_sck = lcd_sck;
        p_cs_n = lcd_cs_n;
        p_dc = lcd_dc;
    end

    bit first_byte = 1;
    bit prev_type = 0;

    task automatic send(input logic [7:0] b, input bit isd, input bit gap);
        if (gap) begin
            in_valid = 1'b0;
            repeat (idle_gap($urandom)) @(negedge clk);
        end
        in_byte    = b;
        in_is_data = isd;
        in_valid   = 1'b1;
        exp_q.push_back({want_new_frame(first_byte, gap, isd, prev_type), isd, b});
        sent++;
        first_byte = 0;
        prev_type  = isd;
        forever begin
            if (in_ready) begin
                @(posedge clk);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int rst_rise;
        int rdy_rise;
        void'($urandom(32'h5EED_1234));
        rst_rise = -1;
        rdy_rise = -1;
        repeat (4) @(negedge clk);
        // R10 outputs under reset
        check(lcd_cs_n == 1'b1, "R10 cs_n in reset", lcd_cs_n, 1);
        check(lcd_sck == 1'b0, "R10 sck in reset", lcd_sck, 0);
        check(lcd_rst_n == 1'b0, "R10 lcd_rst_n in reset", lcd_rst_n, 0);
        check(in_ready == 1'b0, "R10 ready in reset", in_ready, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= RLOW + RWAIT + 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_rise < 0 && lcd_rst_n) rst_rise = k;
            if (rdy_rise < 0 && in_ready) rdy_rise = k;
            if (rst_rise >= 0 && !lcd_rst_n)
                check(0, "R1 lcd_rst_n fell again", 0, 1);
        end
        check(rst_rise == RLOW, "R1 reset release edge", rst_rise, RLOW);
        check(rdy_rise == RLOW + RWAIT, "R2 ready edge", rdy_rise, RLOW + RWAIT);
        check(lcd_cs_n == 1'b1, "R8 idle cs after init", lcd_cs_n, 1);
        p_dc = lcd_dc;
        dc_chg_cyc = cyc - 100;
        mon_en = 1;

        // directed corners
        send(8'h00, 1'b0, 1'b0);
        send(8'hFF, 1'b1, 1'b0);
        send(8'hA5, 1'b1, 1'b0);
        send(8'h5A, 1'b1, 1'b0);
        send(8'h80, 1'b0, 1'b0);
        send(8'h01, 1'b0, 1'b1);
        send(8'h3C, 1'b1, 1'b1);
        send(8'hC3, 1'b0, 1'b0);

        // random mix
        for (int i = 0; i < 70; i++) begin
            logic [7:0] b;
            bit isd;
            bit gap;
            b   = 8'($urandom);
            isd = (($urandom % 4) == 0) ? !prev_type : prev_type;
            gap = (($urandom % 5) == 0);
            send(b, isd, gap);
        end
        in_valid = 1'b0;

        repeat (30 * DIV) @(negedge clk);
        check(lcd_cs_n == 1'b1, "R8 cs released when idle", lcd_cs_n, 1);
        check(lcd_sck == 1'b0, "R8 sck low when idle", lcd_sck, 0);
        check(exp_q.size() == 0, "R9 bytes outstanding", exp_q.size(), 0);
        check(got == sent, "R9 byte count", got, sent);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(0, "R9 watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule